// File: doc/BRIEF.md
# Link-Loss Holdover Recovery Controller

This controller watches over a clock-recovery PLL while a serial link is lost and later restored. When the upstream receive logic reports that no port is available, the controller places the PLL in holdover. In holdover the PLL hold control and the preset-enable control are both driven high, so the loop runs from preset values that were loaded earlier.

To find out whether the cable has been plugged back in, the controller cycles the receiver power. It requests a power-down for a fixed interval, then powers the receiver up and watches receiver ready, lane lock and the monitor's link-status flag over a qualification window. If the link qualifies, the controller watches the PLL frequency-lock flag over a longer window. It releases holdover only when lock has stayed up for that whole window. It then goes back to idle and waits for the next loss indication.

All three intervals are cycle-count parameters. Their defaults are derived from a clock-rate parameter of 156.25 MHz and give 100 µs, 4 ms and 200 ms. A bench can override them with small values.

Top module: `holdover_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller goes idle with `pll_hold_o`, `preset_en_o` and `rx_pwrdn_o` all 0, and its timers are cleared.
- R2: In idle, a high `no_port_i` at a clock edge raises `pll_hold_o` and `preset_en_o` in the next cycle. `rx_pwrdn_o` stays 0 in that first holdover cycle.
- R3: In the cycle after holdover entry, `rx_pwrdn_o` goes high and stays high for exactly `OFF_CYC` cycles.
- R4: After the power-down interval, `rx_pwrdn_o` is low for a window of `QUAL_CYC` cycles. If any of `rx_ready_i`, `lane_lock_i` or `link_up_i` is low at any edge of that window, including the last edge, `rx_pwrdn_o` rises again in the cycle after the window and the power cycle repeats.
- R5: If all three qualifiers are high at every edge of the window, the controller spends one lock-read cycle and then a lock window of `LOCK_CYC` cycles. Holdover stays asserted throughout and `rx_pwrdn_o` stays 0.
- R6: A low `pll_lock_i` at any edge of the lock window sends the controller back to the lock-read cycle, and a fresh lock window follows. Holdover is kept.
- R7: If `pll_lock_i` is high at every edge of the lock window, `pll_hold_o` and `preset_en_o` fall in the next cycle. From the first cycle with `rx_pwrdn_o` low, this is `QUAL_CYC + 1 + LOCK_CYC` cycles after a clean pass.
- R8: `pll_hold_o` always equals `preset_en_o`, and `rx_pwrdn_o` is high only while holdover is asserted.
- R9: `no_port_i` has no effect outside idle. After holdover is released, the controller is idle again one cycle later and re-enters holdover on the next `no_port_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| no_port_i | input | 1 | Link lost, no port available |
| rx_ready_i | input | 1 | Receiver ready from transceiver |
| lane_lock_i | input | 1 | Lane lock from transceiver |
| link_up_i | input | 1 | Link-status flag from frequency monitor |
| pll_lock_i | input | 1 | PLL frequency-lock flag |
| pll_hold_o | output | 1 | PLL hold control |
| preset_en_o | output | 1 | PLL preset-value enable |
| rx_pwrdn_o | output | 1 | Receiver power-down request |

## Verification
The end of a stability window and a failing sample can fall in the same cycle. The decision at the last edge must then include that sample as well as the failures already held in the sticky flag.

The bench provokes this in a directed test. It drops `lane_lock_i` only for the final edge of the qualification window and expects `rx_pwrdn_o` to rise in the next cycle. It likewise drops `pll_lock_i` only at the final edge of the lock window and expects holdover to remain.

Random stimulus runs with a fixed seed. A cycle-level model in the bench, computed from the requirements, judges every cycle.

// File: rtl/hold_pkg.sv
// Package: shared state type for the holdover recovery controller.
// Assumes: seven states fit in three bits; encoding carries no meaning.
package hold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ENTER  = 3'd1,
        ST_RXOFF  = 3'd2,
        ST_RXON   = 3'd3,
        ST_LREAD  = 3'd4,
        ST_LCHECK = 3'd5,
        ST_EXIT   = 3'd6
    } hold_state_e;

endpackage

// File: rtl/hold_window_timer.sv
// Module: window timer. Counts cycles since the last restart and flags the
// final cycle of a window of `limit` cycles.
// Assumes: limit >= 1; restart is pulsed on every state change.
module hold_window_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count elapsed cycles in the current window, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The final cycle of the window is the one whose count equals limit-1.
    always_comb begin
        expire = (cnt_q == (limit - 1'b1));
    end
endmodule

// File: rtl/hold_stab_tracker.sv
// Module: stability tracker. Remembers whether a watched signal was ever low
// inside the current window; reports stability including the present sample.
// Assumes: restart coincides with the start of every window.
module hold_stab_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sample_en,
    input  logic sample,
    output logic stable_now
);
    logic bad_q;

    // Sticky failure flag, cleared when a new window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else if (restart) begin
            bad_q <= 1'b0;
        end else if (sample_en && !sample) begin
            bad_q <= 1'b1;
        end
    end

    // Stable means no earlier dropout and the current sample is high.
    always_comb begin
        stable_now = !bad_q && sample;
    end
endmodule

// File: rtl/hold_fsm.sv
// Module: sequencing FSM. Walks holdover entry, receiver power cycling,
// link qualification, lock check and release; picks the window length.
// Assumes: expire and stable_now refer to the window of the present state.
module hold_fsm
    import hold_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned OFF_CYC  = 4,
    parameter int unsigned QUAL_CYC = 8,
    parameter int unsigned LOCK_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             no_port,
    input  logic             expire,
    input  logic             stable_now,
    output hold_state_e      state,
    output logic             restart,
    output logic [CNT_W-1:0] limit,
    output logic             sample_en,
    output logic             in_qual,
    output logic             hold,
    output logic             pwrdn
);
    hold_state_e state_q;
    hold_state_e state_d;

    // Next-state decision for every phase of the recovery sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (no_port) state_d = ST_ENTER;
            ST_ENTER:  state_d = ST_RXOFF;
            ST_RXOFF:  if (expire) state_d = ST_RXON;
            ST_RXON:   if (expire) state_d = stable_now ? ST_LREAD : ST_RXOFF;
            ST_LREAD:  state_d = ST_LCHECK;
            ST_LCHECK: if (expire) state_d = stable_now ? ST_EXIT : ST_LREAD;
            ST_EXIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Window length for the present state; untimed states use one cycle.
    always_comb begin
        unique case (state_q)
            ST_RXOFF:  limit = CNT_W'(OFF_CYC);
            ST_RXON:   limit = CNT_W'(QUAL_CYC);
            ST_LCHECK: limit = CNT_W'(LOCK_CYC);
            default:   limit = CNT_W'(1);
        endcase
    end

    // Output decode and window control signals.
    always_comb begin
        state     = state_q;
        restart   = (state_d != state_q);
        in_qual   = (state_q == ST_RXON);
        sample_en = (state_q == ST_RXON) || (state_q == ST_LCHECK);
        pwrdn     = (state_q == ST_RXOFF);
        hold      = (state_q == ST_ENTER) || (state_q == ST_RXOFF) ||
                    (state_q == ST_RXON)  || (state_q == ST_LREAD) ||
                    (state_q == ST_LCHECK);
    end
endmodule

// File: rtl/holdover_ctrl.sv
// Module: top of the link-loss holdover recovery controller. Joins the FSM,
// the window timer and the stability tracker.
// Assumes: inputs are synchronous to clk; the interval parameters are >= 1.
module holdover_ctrl
    import hold_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 156250,
    parameter int unsigned OFF_CYC  = CLK_KHZ / 10,
    parameter int unsigned QUAL_CYC = CLK_KHZ * 4,
    parameter int unsigned LOCK_CYC = CLK_KHZ * 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic no_port_i,
    input  logic rx_ready_i,
    input  logic lane_lock_i,
    input  logic link_up_i,
    input  logic pll_lock_i,
    output logic pll_hold_o,
    output logic preset_en_o,
    output logic rx_pwrdn_o
);
    localparam int unsigned MAX_A  = (OFF_CYC > QUAL_CYC) ? OFF_CYC : QUAL_CYC;
    localparam int unsigned MAX_C  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

    hold_state_e      state_w;
    logic             restart_w;
    logic [CNT_W-1:0] limit_w;
    logic             expire_w;
    logic             sample_en_w;
    logic             in_qual_w;
    logic             sample_w;
    logic             stable_w;
    logic             hold_w;
    logic             pwrdn_w;

    // Select the watched signal: link qualifiers or PLL lock.
    always_comb begin
        sample_w = in_qual_w ? (rx_ready_i && lane_lock_i && link_up_i) : pll_lock_i;
    end

    hold_fsm #(
        .CNT_W    (CNT_W),
        .OFF_CYC  (OFF_CYC),
        .QUAL_CYC (QUAL_CYC),
        .LOCK_CYC (LOCK_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .no_port    (no_port_i),
        .expire     (expire_w),
        .stable_now (stable_w),
        .state      (state_w),
        .restart    (restart_w),
        .limit      (limit_w),
        .sample_en  (sample_en_w),
        .in_qual    (in_qual_w),
        .hold       (hold_w),
        .pwrdn      (pwrdn_w)
    );

    hold_window_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .limit   (limit_w),
        .expire  (expire_w)
    );

    hold_stab_tracker u_stab (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart_w),
        .sample_en  (sample_en_w),
        .sample     (sample_w),
        .stable_now (stable_w)
    );

    // Drive the PLL and receiver controls from the decoded state.
    always_comb begin
        pll_hold_o  = hold_w;
        preset_en_o = hold_w;
        rx_pwrdn_o  = pwrdn_w;
    end
endmodule

// File: rtl/holdover_ctrl_chk.sv
// Module: property checker for holdover_ctrl, attached by bind.
// Assumes: the state port reflects the controller's registered state.
module holdover_ctrl_chk
    import hold_pkg::*;
#(
    parameter int unsigned OFF_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        no_port_i,
    input logic        rx_ready_i,
    input logic        lane_lock_i,
    input logic        link_up_i,
    input logic        pll_lock_i,
    input logic        pll_hold_o,
    input logic        preset_en_o,
    input logic        rx_pwrdn_o,
    input hold_state_e state
);
    logic [31:0] off_run;

    // Length of the current power-down run, counted in the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run <= '0;
        end else if (rx_pwrdn_o) begin
            off_run <= off_run + 1;
        end else begin
            off_run <= '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pll_hold_o && !rx_pwrdn_o));

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && no_port_i) |=> (pll_hold_o && !rx_pwrdn_o));

    assert_pwrdn_after_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_hold_o) |=> rx_pwrdn_o);

    assert_off_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pwrdn_o |-> (off_run < OFF_CYC));

    assert_off_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pwrdn_o) |-> (off_run == OFF_CYC));

    assert_qual_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LREAD && $past(state) == ST_RXON) |->
            $past(rx_ready_i && lane_lock_i && link_up_i));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LCHECK) |-> (pll_hold_o && !rx_pwrdn_o));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_hold_o) |-> $past(pll_lock_i));

    assert_hold_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_hold_o == preset_en_o);

    assert_pwrdn_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pwrdn_o |-> pll_hold_o);

    assert_exit_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXIT) |=> (state == ST_IDLE));
endmodule

bind holdover_ctrl holdover_ctrl_chk #(.OFF_CYC(OFF_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .no_port_i   (no_port_i),
    .rx_ready_i  (rx_ready_i),
    .lane_lock_i (lane_lock_i),
    .link_up_i   (link_up_i),
    .pll_lock_i  (pll_lock_i),
    .pll_hold_o  (pll_hold_o),
    .preset_en_o (preset_en_o),
    .rx_pwrdn_o  (rx_pwrdn_o),
    .state       (state_w)
);

// File: tb/holdover_ctrl_bench.sv
// Bench: directed corner cases plus seeded random stimulus, judged each
// cycle against a cycle-level model built from the requirements.
module holdover_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OFF  = 4;
    localparam int QUAL = 8;
    localparam int LOCK = 10;

    localparam int P_IDLE = 0, P_ENTER = 1, P_OFF = 2, P_ON = 3,
                   P_READ = 4, P_CHK = 5, P_EXIT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic no_port = 1'b0, rx_rdy = 1'b1, lane = 1'b1, link = 1'b1, lock = 1'b1;
    logic hold, preset, pwrdn;

    int checks = 0;
    int fails  = 0;
    int ph = P_IDLE, cnt = 0;
    bit bad = 1'b0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    holdover_ctrl #(
        .OFF_CYC (OFF), .QUAL_CYC (QUAL), .LOCK_CYC (LOCK)
    ) u_holdover_ctrl (
        .clk (clk), .rst_n (rst_n), .no_port_i (no_port),
        .rx_ready_i (rx_rdy), .lane_lock_i (lane), .link_up_i (link),
        .pll_lock_i (lock), .pll_hold_o (hold), .preset_en_o (preset),
        .rx_pwrdn_o (pwrdn)
    );

    function automatic bit exp_hold(int p);
        return (p == P_ENTER) || (p == P_OFF) || (p == P_ON) ||
               (p == P_READ) || (p == P_CHK);
    endfunction

    function automatic bit exp_pwrdn(int p);
        return p == P_OFF;
    endfunction

    function automatic string tag_of(int p);
        case (p)
            P_IDLE:  return "R9";
            P_ENTER: return "R2";
            P_OFF:   return "R3";
            P_ON:    return "R4";
            P_READ:  return "R5";
            P_CHK:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {hold,preset,pwrdn} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    // Reference model: advances one phase step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = P_IDLE; cnt = 0; bad = 1'b0;
        end else begin
            int nxt;
            nxt = ph;
            case (ph)
                P_IDLE:  if (no_port) nxt = P_ENTER;
                P_ENTER: nxt = P_OFF;
                P_OFF:   begin cnt++; if (cnt == OFF) nxt = P_ON; end
                P_ON: begin
                    if (!(rx_rdy && lane && link)) bad = 1'b1;
                    cnt++;
                    if (cnt == QUAL) nxt = bad ? P_OFF : P_READ;
                end
                P_READ:  nxt = P_CHK;
                P_CHK: begin
                    if (!lock) bad = 1'b1;
                    cnt++;
                    if (cnt == LOCK) nxt = bad ? P_READ : P_EXIT;
                end
                default: nxt = P_IDLE;
            endcase
            if (nxt != ph) begin ph = nxt; cnt = 0; bad = 1'b0; end
        end
    end

    // Compare every cycle away from the active edge; R8 is part of each check.
    always @(negedge clk) begin
        if (model_on && rst_n)
            check(tag_of(ph), {hold, preset, pwrdn},
                  {exp_hold(ph), exp_hold(ph), exp_pwrdn(ph)});
    end

    task automatic wait_pwrdn_fall();
        while (pwrdn !== 1'b1) @(negedge clk);
        while (pwrdn !== 1'b0) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {hold, preset, pwrdn}, 3'b000);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {hold, preset, pwrdn}, 3'b000);

        // R2: entry on loss, no power-down in the first cycle
        no_port = 1'b1;
        @(negedge clk);
        no_port = 1'b0;
        check("R2", {hold, preset, pwrdn}, 3'b110);
        @(negedge clk);
        check("R3", {hold, preset, pwrdn}, 3'b111);

        // R4: dropout only at the last edge of the qualification window
        wait_pwrdn_fall();
        repeat (QUAL - 1) @(negedge clk);
        lane = 1'b0;
        @(negedge clk);
        lane = 1'b1;
        check("R4", {hold, preset, pwrdn}, 3'b111);

        // R6: lock drop only at the last edge of the lock window
        wait_pwrdn_fall();
        repeat (QUAL + 1 + LOCK - 1) @(negedge clk);
        lock = 1'b0;
        @(negedge clk);
        lock = 1'b1;
        check("R6", {hold, preset, pwrdn}, 3'b110);
        // R9: loss indication during holdover is ignored
        no_port = 1'b1;
        repeat (1 + LOCK) @(negedge clk);
        no_port = 1'b0;
        // R7: release after a clean lock window
        check("R7", {hold, preset, pwrdn}, 3'b000);
        @(negedge clk);
        check("R9", {hold, preset, pwrdn}, 3'b000);

        // R5/R7: clean pass timing from the first powered-up cycle
        no_port = 1'b1;
        @(negedge clk);
        no_port = 1'b0;
        wait_pwrdn_fall();
        repeat (QUAL) @(negedge clk);
        check("R5", {hold, preset, pwrdn}, 3'b110);
        repeat (LOCK) @(negedge clk);
        check("R7", {hold, preset, pwrdn}, 3'b110);
        @(negedge clk);
        check("R7", {hold, preset, pwrdn}, 3'b000);

        // Seeded random stimulus, judged by the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            no_port = ($urandom % 100) < 4;
            rx_rdy  = ($urandom % 100) < 97;
            lane    = ($urandom % 100) < 97;
            link    = ($urandom % 100) < 97;
            lock    = ($urandom % 100) < 95;
            @(negedge clk);
        end

        // R1: reset in the middle of holdover
        no_port = 1'b1;
        @(negedge clk);
        no_port = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {hold, preset, pwrdn}, 3'b000);
        summary();
    end
endmodule